// File: doc/BRIEF.md
# Asynchronous Receive Stop-Bit Restorer

This block follows the descrambler in a 1200 bit/s modem receiver and drives the receive data line. In synchronous mode the incoming bit stream is forwarded as it arrives. In asynchronous mode the block recovers character frames from the stream and stores complete characters in a small queue. It then sends them out again with a bit period slightly shorter than the line's. The default divider of 3024 on a 3.6864 MHz clock gives about 1219.05 bit/s. Because the output runs faster, the stop interval between characters stretches or shrinks as needed.

A far-end transmitter that receives data faster than it can send may drop a stop bit now and then. When a space appears where a stop bit belongs, this block completes the character with a mark stop bit. It then treats that space as the start bit of the next character. Each character is re-emitted with a full stop bit.

The input is a strobed bit stream: `in_valid` marks each bit from the recovered clock. There is no ready signal, because a modem line cannot be stalled. Every strobed bit is taken. If a finished character finds the queue full, the new character is dropped, the older ones are kept, and a sticky flag is raised.

Top module: `async_stop_restorer`

## Requirements
- R1: After reset `rxd` is 1 and `overflow` is 0.
- R2: While `sync_mode` is 1, `rxd` equals the `in_bit` value of the most recent strobe, from the cycle after that strobe. The async framer, queue and serializer are held cleared in this mode.
- R3: Frame length in bits is 8 + `len_sel` (`len_sel` 0,1,2,3 gives 8,9,10,11). A frame is one 0 start bit, then `len_sel`+6 data bits with the least significant bit first, then a stop bit. `len_sel` is changed only while the block is idle.
- R4: A character with a mark stop bit, followed by any number of idle marks, is re-emitted with identical data bits and a mark stop bit.
- R5: A 0 received at the stop position completes the current character. That character is re-emitted with a mark stop bit, and the same 0 starts the next character.
- R6: Every output bit lasts exactly `OUT_DIV` clock cycles, and the output changes only on the internal bit tick.
- R7: When characters are waiting, a new character starts right after one stop bit, so character starts are `frame length × OUT_DIV` cycles apart. Otherwise the stop interval stretches as needed.
- R8: A character starts on `rxd` only after its stop position has been received.
- R9: The queue holds `FIFO_DEPTH` characters in addition to the one being sent. A character completed while the queue is full is discarded, the older ones are kept, and `overflow` goes to 1 and stays there until reset.
- R10: In asynchronous mode `rxd` is 1 whenever no character is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1: pass the stream straight through; 0: restore async characters |
| len_sel | input | 2 | Frame length select, length = 8 + value |
| in_valid | input | 1 | One-cycle strobe marking a received bit |
| in_bit | input | 1 | Received bit, qualified by `in_valid` |
| rxd | output | 1 | Receive data line |
| overflow | output | 1 | Sticky flag, set when a completed character is dropped |

## Verification
The hardest condition to reach is a full queue while a character is still being sent. The output drains faster than the line fills it, so normally spaced strobes never get there. The bench first sends one character at line rate and waits until its start bit appears on `rxd`. It then strobes four more characters on consecutive clock cycles, so the queue fills and the last two are dropped while the serializer is still busy. The deleted-stop case is reached by sending a 0 in the stop position. The bench then measures the spacing between the two output start bits, which tests both the reinsertion and the elastic stop together.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int MAX_DATA = 9;

  typedef logic [MAX_DATA-1:0] char_t;

  // Total bits in a frame: start + data + stop.
  function automatic logic [3:0] frame_bits(input logic [1:0] sel);
    return 4'd8 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/asr_deframer.sv
module asr_deframer
  import asr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] len_sel,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       out_valid,
  output char_t      out_data
);
  logic       busy;
  logic [3:0] pos;
  char_t      sh;
  logic [3:0] stop_pos;

  assign stop_pos = frame_bits(len_sel) - 4'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      busy      <= 1'b0;
      pos       <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (bit_valid) begin
        if (!busy) begin
          if (!bit_in) begin
            busy <= 1'b1;
            pos  <= 4'd1;
            sh   <= '0;
          end
        end else if (pos == stop_pos) begin
          out_valid <= 1'b1;
          out_data  <= sh;
          sh        <= '0;
          if (bit_in) begin
            busy <= 1'b0;
          end else begin
            pos <= 4'd1;
          end
        end else begin
          sh[pos - 4'd1] <= bit_in;
          pos            <= pos + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/asr_fifo.sv
module asr_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic             wr_en, rd_en;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign wr_en     = in_valid && in_ready;
  assign rd_en     = out_valid && out_ready;
  assign out_data  = slot_q[rptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && wptr == AW'(g)) begin
        q <= in_data;
      end
    end
    assign slot_q[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/asr_serializer.sv
module asr_serializer
  import asr_pkg::*;
#(
  parameter int DIV = 3024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] len_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  char_t      in_data,
  output logic       line,
  output logic       tick,
  output logic       busy
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNTW-1:0] cnt;
  logic [3:0]      pos;
  logic [3:0]      last;
  char_t           sh;

  assign last     = frame_bits(len_sel) - 4'd1;
  assign tick     = (cnt == CNTW'(DIV - 1));
  assign in_ready = tick && (!busy || pos == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      busy <= 1'b0;
      pos  <= '0;
      sh   <= '0;
      line <= 1'b1;
    end else if (tick) begin
      if (in_valid && in_ready) begin
        busy <= 1'b1;
        pos  <= '0;
        sh   <= in_data;
        line <= 1'b0;
      end else if (busy) begin
        if (pos == last) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          pos  <= pos + 4'd1;
          line <= (pos + 4'd1 == last) ? 1'b1 : sh[0];
          sh   <= sh >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/async_stop_restorer.sv
module async_stop_restorer
  import asr_pkg::*;
#(
  parameter int OUT_DIV    = 3024,
  parameter int FIFO_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic [1:0] len_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       rxd,
  output logic       overflow
);
  logic  fr_valid;
  char_t fr_data;
  logic  fifo_in_ready;
  logic  fifo_out_valid;
  char_t fifo_out_data;
  logic  ser_ready;
  logic  ser_line;
  logic  ser_tick;
  logic  ser_busy;
  logic  sync_q;

  asr_deframer u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sync_mode),
    .len_sel   (len_sel),
    .bit_valid (in_valid),
    .bit_in    (in_bit),
    .out_valid (fr_valid),
    .out_data  (fr_data)
  );

  asr_fifo #(.WIDTH(MAX_DATA), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sync_mode),
    .in_valid  (fr_valid),
    .in_ready  (fifo_in_ready),
    .in_data   (fr_data),
    .out_valid (fifo_out_valid),
    .out_ready (ser_ready),
    .out_data  (fifo_out_data)
  );

  asr_serializer #(.DIV(OUT_DIV)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sync_mode),
    .len_sel  (len_sel),
    .in_valid (fifo_out_valid),
    .in_ready (ser_ready),
    .in_data  (fifo_out_data),
    .line     (ser_line),
    .tick     (ser_tick),
    .busy     (ser_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= 1'b1;
      overflow <= 1'b0;
    end else begin
      if (in_valid) sync_q <= in_bit;
      if (fr_valid && !fifo_in_ready) overflow <= 1'b1;
    end
  end

  assign rxd = sync_mode ? sync_q : ser_line;
endmodule

// File: rtl/asr_checker.sv
module asr_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic in_valid,
  input logic in_bit,
  input logic rxd,
  input logic overflow,
  input logic tick,
  input logic fr_valid,
  input logic fifo_ready,
  input logic ser_busy
);
  assert_sync_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode && $past(sync_mode) && $past(in_valid) |-> rxd == $past(in_bit));

  assert_tick_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode && !$past(sync_mode) && !$past(tick) |-> $stable(rxd));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fr_valid && !fifo_ready));

  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode && !ser_busy |-> rxd);
endmodule

bind async_stop_restorer asr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_mode  (sync_mode),
  .in_valid   (in_valid),
  .in_bit     (in_bit),
  .rxd        (rxd),
  .overflow   (overflow),
  .tick       (ser_tick),
  .fr_valid   (fr_valid),
  .fifo_ready (fifo_in_ready),
  .ser_busy   (ser_busy)
);

// File: tb/async_stop_restorer_bench.sv
module async_stop_restorer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OUT_DIV    = 63;
  localparam int IN_GAP     = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic [1:0] len_sel = 2'd2;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b1;
  logic       rxd;
  logic       overflow;

  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;
  int   dbits = 8;
  int   strobe_cyc = 0;
  int   cap_n = 0;
  logic [8:0] cap_d [16];
  int   cap_t [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_stop_restorer #(.OUT_DIV(OUT_DIV), .FIFO_DEPTH(2)) u_async_stop_restorer (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .len_sel(len_sel),
    .in_valid(in_valid), .in_bit(in_bit), .rxd(rxd), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Output frame monitor: decodes rxd at mid-bit.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rxd === 1'b0) begin
        int t0;
        logic [8:0] v;
        t0 = cyc;
        v  = '0;
        repeat (OUT_DIV/2) @(negedge clk);
        chk(rxd == 1'b0, "R3 start bit", int'(rxd), 0);
        for (int i = 0; i < dbits; i++) begin
          repeat (OUT_DIV) @(negedge clk);
          v[i] = rxd;
        end
        repeat (OUT_DIV) @(negedge clk);
        chk(rxd == 1'b1, "R5 stop bit present", int'(rxd), 1);
        if (cap_n < 16) begin
          cap_d[cap_n] = v;
          cap_t[cap_n] = t0;
        end
        cap_n++;
      end
    end
  end

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk);
    in_bit   = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    strobe_cyc = cyc;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_char(input logic [8:0] d, input bit drop_stop, input int gap);
    send_bit(1'b0, gap);
    for (int i = 0; i < dbits; i++) send_bit(d[i], gap);
    if (!drop_stop) send_bit(1'b1, gap);
  endtask

  task automatic drain(input int nchar);
    repeat (OUT_DIV * 12 * nchar + 200) @(negedge clk);
  endtask

  task automatic set_len(input logic [1:0] s);
    len_sel = s;
    dbits   = int'(s) + 6;
    cap_n   = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rxd == 1'b1, "R1 rxd after reset", int'(rxd), 1);
    chk(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
    repeat (3 * OUT_DIV) @(negedge clk);
    chk(rxd == 1'b1, "R10 idle mark", int'(rxd), 1);
  endtask

  task automatic t_sync;
    logic [5:0] pat = 6'b101001;
    mon_en = 1'b0;
    sync_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_bit = pat[i];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      in_bit = ~pat[i];
      chk(rxd == pat[i], "R2 sync pass-through", int'(rxd), int'(pat[i]));
      repeat (i + 2) @(negedge clk);
      chk(rxd == pat[i], "R2 sync hold", int'(rxd), int'(pat[i]));
    end
    sync_mode = 1'b0;
    in_bit = 1'b1;
    repeat (2) @(negedge clk);
    chk(rxd == 1'b1, "R10 mark after leaving sync", int'(rxd), 1);
  endtask

  task automatic t_under;
    int stop_at;
    set_len(2'd2);
    mon_en = 1'b1;
    send_char(9'h0A5, 1'b0, IN_GAP);
    stop_at = strobe_cyc;
    send_bit(1'b1, IN_GAP);
    send_bit(1'b1, IN_GAP);
    send_char(9'h03C, 1'b0, IN_GAP);
    drain(2);
    chk(cap_n == 2, "R4 char count", cap_n, 2);
    chk(cap_d[0] == 9'h0A5, "R4 first char", int'(cap_d[0]), 'hA5);
    chk(cap_d[1] == 9'h03C, "R4 second char", int'(cap_d[1]), 'h3C);
    chk(cap_t[0] > stop_at, "R8 store before send", cap_t[0], stop_at + 1);
    chk(cap_t[1] - cap_t[0] >= 10 * OUT_DIV, "R7 elastic spacing",
        cap_t[1] - cap_t[0], 10 * OUT_DIV);
  endtask

  task automatic t_deleted(input logic [1:0] s, input logic [8:0] a, input logic [8:0] b);
    int nb;
    set_len(s);
    nb = int'(s) + 8;
    mon_en = 1'b1;
    send_char(a, 1'b1, IN_GAP);
    send_char(b, 1'b0, IN_GAP);
    drain(2);
    chk(cap_n == 2, "R5 char count", cap_n, 2);
    chk(cap_d[0] == a, "R5 char before deleted stop", int'(cap_d[0]), int'(a));
    chk(cap_d[1] == b, "R5 char after deleted stop", int'(cap_d[1]), int'(b));
    chk(cap_t[1] - cap_t[0] == nb * OUT_DIV, "R6 R7 back-to-back period",
        cap_t[1] - cap_t[0], nb * OUT_DIV);
  endtask

  task automatic t_len8;
    set_len(2'd0);
    mon_en = 1'b1;
    send_char(9'h02B, 1'b0, IN_GAP);
    send_char(9'h015, 1'b0, IN_GAP);
    drain(2);
    chk(cap_n == 2, "R3 eight-bit frame count", cap_n, 2);
    chk(cap_d[0] == 9'h02B, "R3 eight-bit frame a", int'(cap_d[0]), 'h2B);
    chk(cap_d[1] == 9'h015, "R3 eight-bit frame b", int'(cap_d[1]), 'h15);
  endtask

  task automatic t_overflow;
    set_len(2'd2);
    mon_en = 1'b1;
    send_char(9'h011, 1'b0, IN_GAP);
    while (rxd !== 1'b0) @(negedge clk);
    chk(overflow == 1'b0, "R9 no overflow yet", int'(overflow), 0);
    send_char(9'h022, 1'b0, 1);
    send_char(9'h033, 1'b0, 1);
    send_char(9'h044, 1'b0, 1);
    send_char(9'h055, 1'b0, 1);
    @(negedge clk);
    chk(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
    drain(4);
    chk(cap_n == 3, "R9 kept count", cap_n, 3);
    chk(cap_d[1] == 9'h022, "R9 oldest kept b", int'(cap_d[1]), 'h22);
    chk(cap_d[2] == 9'h033, "R9 oldest kept c", int'(cap_d[2]), 'h33);
    chk(overflow == 1'b1, "R9 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_under();
    t_deleted(2'd2, 9'h0C3, 9'h05A);
    t_deleted(2'd3, 9'h1A5, 9'h05A);
    t_len8();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule